// File: doc/BRIEF.md
# Byte-Wide SPI Master with Per-Byte Chip-Select Hold

This block is a byte-oriented SPI master controlled through a 16-bit control register and an 8-bit data register. Software sets the bus enable, a two-bit rate code, a target peripheral (one of three) and two policy bits. It then writes a byte to the data register. That write starts a full-duplex, MSB-first exchange in SPI mode 0: SCK idles low, the peripheral's data is sampled on the rising edge, and outgoing data changes on the falling edge. When the exchange ends, the received byte replaces the data register contents, where software can read it.

A hold bit decides, at the end of each byte, whether the selected chip select stays asserted. This lets several bytes form one command frame. A read-only busy bit and an optional one-cycle interrupt pulse report progress. The SCK half period is `HALF_BASE << rate` system clocks, so each step of the rate code halves the bit rate. With a 200 MHz system clock, `HALF_BASE = 25` gives a 4 MHz top rate.

The engine state machine has five states. It waits in `ST_IDLE` and takes the transition *start* to `ST_LEAD` when an accepted data write arrives. `ST_LEAD` holds SCK low for one half period with chip select already asserted. The transition *rise* then moves it to `ST_HIGH`. On *fall*, it goes from `ST_HIGH` to `ST_LOW` when more bits remain. On *rise*, it goes from `ST_LOW` back to `ST_HIGH`. On *last*, it goes from `ST_HIGH` to `ST_FINISH` after the eighth high phase. On *retire*, it goes from `ST_FINISH` to `ST_IDLE` after one cycle. During that cycle the data register is loaded, chip select is released or kept, and the interrupt is raised.

Top module: `legacy_spi_master`

## Requirements
- R1: The rate code in control bits 1:0 (value c) sets the SCK half period to HALF_BASE<<c system clocks. A transfer therefore keeps the busy bit set for exactly 16*(HALF_BASE<<c)+1 cycles.
- R2: Control bit 7 reads 1 while a transfer is in progress and 0 otherwise. On reads, only bits 15, 14, 11, 9:8, 7 and 1:0 can be nonzero.
- R3: Control bits 9:8 choose the device. Device d in 0..2 drives only cs_n[d] low (active low) during its transfer. Device 3 drives no chip select.
- R4: A data-register write while bit 15 is 1 and the block is idle starts an 8-bit exchange. The exchange is MSB first in SPI mode 0. The received byte is readable from the data register once busy clears.
- R5: A data-register write while busy, or while bit 15 is 0, is ignored. It starts nothing, leaves the data register unchanged and does not disturb a running exchange.
- R6: If control bit 11 (hold) is 0 at completion, chip select is released. If it is 1, chip select stays asserted. Clearing hold and then transferring one more byte releases a held chip select.
- R7: SCK idles low. The first rising SCK edge comes no earlier than one half period after chip select asserts.
- R8: Bit 14 set at the moment of completion produces a one-cycle irq pulse, in the cycle in which busy first reads 0. If bit 14 is 0 at that moment, no pulse is produced.
- R9: While busy, a control write updates only bits 11 and 14. The rate, device and enable fields keep their values.
- R10: After reset, the control and data registers read 0, every cs_n is high, and sck and irq are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Control register read value including busy |
| dat_wr | input | 1 | Data register write strobe (starts a transfer) |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rdata | output | 8 | Data register: last written or last received byte |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NDEV | Active-low chip selects, one per device |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench instantiates the block with HALF_BASE = 2 and the default three devices. At that setting all four rate codes are exercised, and the slowest code still needs only 257 busy cycles. Exact transfer lengths and the half-period lead of chip select can therefore be counted for every rate. The unused device code 3, and a device select that would index past the chip-select vector, are also reached with that device count.

// File: rtl/lspi_pkg.sv
package lspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_FINISH
    } lspi_state_e;

    // control register bit positions (software-visible layout)
    localparam int CB_RATE   = 0;
    localparam int CB_BUSY   = 7;
    localparam int CB_DSEL   = 8;
    localparam int CB_HOLD   = 11;
    localparam int CB_IRQEN  = 14;
    localparam int CB_ENABLE = 15;

    localparam int RATE_W = 2;
    localparam int DSEL_W = 2;

endpackage

// File: rtl/lspi_divider.sv
module lspi_divider #(
    parameter int HALF_BASE = 25
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic [lspi_pkg::RATE_W-1:0] rate,
    output logic                       tick
);
    localparam int MAX_HALF = HALF_BASE << ((1 << lspi_pkg::RATE_W) - 1);
    localparam int CNT_W    = $clog2(MAX_HALF + 1);
    localparam logic [CNT_W-1:0] HB = CNT_W'(HALF_BASE);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = (HB << rate) - 1'b1;
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: the half-period counter never passes the limit set by the rate code
    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit));

endmodule

// File: rtl/lspi_engine.sv
module lspi_engine
    import lspi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tick,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       run,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    lspi_state_e state, state_nx;
    logic [7:0]  tx_sh;
    logic [2:0]  bit_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: start, rise, fall, last, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_LEAD;
            ST_LEAD:   if (tick)  state_nx = ST_HIGH;
            ST_HIGH:   if (tick)  state_nx = (bit_cnt == 3'd7) ? ST_FINISH : ST_LOW;
            ST_LOW:    if (tick)  state_nx = ST_HIGH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_byte <= '0;
            bit_cnt <= '0;
        end else if (state == ST_IDLE && start) begin
            tx_sh   <= tx_byte;
            bit_cnt <= '0;
        end else if (tick && (state == ST_LEAD || state == ST_LOW)) begin
            rx_byte <= {rx_byte[6:0], miso};
        end else if (tick && state == ST_HIGH && bit_cnt != 3'd7) begin
            tx_sh   <= {tx_sh[6:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy = 1'b1;
        run  = 1'b0;
        sck  = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_LEAD:   run  = 1'b1;
            ST_HIGH:   begin run = 1'b1; sck = 1'b1; end
            ST_LOW:    run  = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end
    assign mosi = tx_sh[7];

    // R4: outgoing data only changes while SCK is low
    a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/legacy_spi_master.sv
module legacy_spi_master
    import lspi_pkg::*;
#(
    parameter int HALF_BASE = 25,
    parameter int NDEV      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [15:0]     ctl_wdata,
    output logic [15:0]     ctl_rdata,
    input  logic            dat_wr,
    input  logic [7:0]      dat_wdata,
    output logic [7:0]      dat_rdata,
    output logic            sck,
    output logic            mosi,
    input  logic            miso,
    output logic [NDEV-1:0] cs_n,
    output logic            irq
);
    logic              en_q, ie_q, hold_q;
    logic [DSEL_W-1:0] dsel_q, cs_dev;
    logic [RATE_W-1:0] rate_q;
    logic [7:0]        data_q, rx_byte;
    logic              cs_act, irq_q;
    logic              busy, run, tick, done, start;

    assign start = dat_wr && en_q && !busy;

    lspi_divider #(.HALF_BASE(HALF_BASE)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .rate  (rate_q),
        .tick  (tick)
    );

    lspi_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .tx_byte (dat_wdata),
        .miso    (miso),
        .busy    (busy),
        .run     (run),
        .sck     (sck),
        .mosi    (mosi),
        .done    (done),
        .rx_byte (rx_byte)
    );

    // control register: policy bits always writable, the rest only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            hold_q <= 1'b0;
            dsel_q <= '0;
            rate_q <= '0;
        end else if (ctl_wr) begin
            hold_q <= ctl_wdata[CB_HOLD];
            ie_q   <= ctl_wdata[CB_IRQEN];
            if (!busy) begin
                en_q   <= ctl_wdata[CB_ENABLE];
                dsel_q <= ctl_wdata[CB_DSEL +: DSEL_W];
                rate_q <= ctl_wdata[CB_RATE +: RATE_W];
            end
        end
    end

    // data register, chip-select state and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            cs_act <= 1'b0;
            cs_dev <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= done && ie_q;
            if (start) begin
                data_q <= dat_wdata;
                cs_act <= 1'b1;
                cs_dev <= dsel_q;
            end else if (done) begin
                data_q <= rx_byte;
                if (!hold_q) cs_act <= 1'b0;
            end
        end
    end

    generate
        for (genvar d = 0; d < NDEV; d++) begin : g_cs
            assign cs_n[d] = !(cs_act && (cs_dev == DSEL_W'(d)));
        end
    endgenerate

    always_comb begin
        ctl_rdata                       = '0;
        ctl_rdata[CB_RATE +: RATE_W]    = rate_q;
        ctl_rdata[CB_BUSY]              = busy;
        ctl_rdata[CB_DSEL +: DSEL_W]    = dsel_q;
        ctl_rdata[CB_HOLD]              = hold_q;
        ctl_rdata[CB_IRQEN]             = ie_q;
        ctl_rdata[CB_ENABLE]            = en_q;
    end
    assign dat_rdata = data_q;
    assign irq       = irq_q;

    // R3: never more than one chip select low
    a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R7: SCK only toggles high with chip-select state already active and steady
    a_r7_cs_before_sck: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> (cs_act && $past(cs_act)));
    // R8: interrupt is a single-cycle pulse
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R5: data register is frozen while shifting
    a_r5_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(data_q));
    // R9: rate and device fields do not move during a transfer
    a_r9_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(rate_q) && $stable(dsel_q) && $stable(en_q)));

endmodule

// File: tb/sim_legacy_spi_master.sv
`timescale 1ns/1ps
module sim_legacy_spi_master;
    localparam int HB   = 2;
    localparam int NDEV = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ctl_wr = 1'b0;
    logic [15:0]     ctl_wdata = '0;
    logic [15:0]     ctl_rdata;
    logic            dat_wr = 1'b0;
    logic [7:0]      dat_wdata = '0;
    logic [7:0]      dat_rdata;
    logic            sck, mosi, miso;
    logic [NDEV-1:0] cs_n;
    logic            irq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    legacy_spi_master #(.HALF_BASE(HB), .NDEV(NDEV)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .dat_rdata(dat_rdata), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .irq(irq)
    );

    // peripheral model: mode 0, shifts out on falling SCK, captures on rising
    logic [7:0] s_tx = '0;
    logic [7:0] s_rx = '0;
    int         s_negs = 0;
    int         s_base = 0;
    logic [2:0] s_sel;
    assign s_sel = 3'(s_negs - s_base);
    assign miso  = s_tx[3'd7 - s_sel];
    always @(posedge sck) s_rx = {s_rx[6:0], mosi};
    always @(negedge sck) s_negs = s_negs + 1;

    // results of the last transfer
    int          r_n, r_first_hi;
    logic [2:0]  r_cs_mid, r_cs_after;
    logic        r_irq_end, r_irq_next;

    localparam logic [15:0] EN = 16'h8000;
    localparam logic [15:0] IE = 16'h4000;
    localparam logic [15:0] HOLD = 16'h0800;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic xfer(input logic [15:0] ctl, input logic [7:0] tx, input logic [7:0] stx,
                        input bit mid_ctl, input logic [15:0] mid_val, input bit mid_dat);
        int h;
        h = HB << ctl[1:0];
        wr_ctl(ctl);
        s_tx = stx; s_base = s_negs;
        dat_wr = 1'b1; dat_wdata = tx;
        @(negedge clk);
        dat_wr = 1'b0;
        r_n = 0; r_first_hi = 0; r_cs_mid = '1;
        while (ctl_rdata[7]) begin
            r_n++;
            if (sck && r_first_hi == 0) r_first_hi = r_n;
            if (r_n == h + 1) r_cs_mid = cs_n;
            if (mid_ctl && r_n == 4) begin ctl_wr = 1'b1; ctl_wdata = mid_val; end
            if (mid_dat && r_n == 5) begin dat_wr = 1'b1; dat_wdata = 8'h5A; end
            @(negedge clk);
            ctl_wr = 1'b0; dat_wr = 1'b0;
            if (r_n > 2000) break;
        end
        r_irq_end = irq; r_cs_after = cs_n;
        @(negedge clk);
        r_irq_next = irq;
    endtask

    task automatic t_reset;
        chk(ctl_rdata == 16'h0, "R10 ctl", ctl_rdata, 0);
        chk(dat_rdata == 8'h0, "R10 data", dat_rdata, 0);
        chk(cs_n == 3'b111, "R10 cs_n", cs_n, 7);
        chk(!sck && !irq, "R10 sck/irq", {sck, irq}, 0);
    endtask

    task automatic t_rates;
        for (int r = 0; r < 4; r++) begin
            int h;
            logic [7:0] tx, stx;
            h = HB << r;
            tx = 8'hA5 ^ 8'(r * 37);
            stx = 8'h3C + 8'(r * 29);
            xfer(EN | 16'(r), tx, stx, 0, 0, 0);
            chk(r_n == 16 * h + 1, "R1 busy length", r_n, 16 * h + 1);
            chk(r_first_hi == h + 1, "R7 cs lead", r_first_hi, h + 1);
            chk(s_rx == tx, "R4 mosi byte", s_rx, tx);
            chk(dat_rdata == stx, "R4 miso byte", dat_rdata, stx);
            chk(r_cs_mid == 3'b110, "R3 dev0", r_cs_mid, 6);
            chk(r_cs_after == 3'b111 && !sck, "R6 release", r_cs_after, 7);
            chk(r_irq_end == 0, "R8 no irq", r_irq_end, 0);
        end
    endtask

    task automatic t_devices;
        for (int d = 1; d < 4; d++) begin
            logic [2:0] exp;
            exp = (d < 3) ? ~(3'b001 << d) : 3'b111;
            xfer(EN | 16'(d << 8), 8'h81, 8'h18, 0, 0, 0);
            chk(r_cs_mid == exp, "R3 device select", r_cs_mid, exp);
            chk(dat_rdata == 8'h18, "R4 data", dat_rdata, 8'h18);
        end
    endtask

    task automatic t_hold;
        xfer(EN | HOLD | 16'h0200, 8'h11, 8'h22, 0, 0, 0);
        chk(r_cs_after == 3'b011, "R6 hold keeps cs", r_cs_after, 3);
        xfer(EN | HOLD | 16'h0200, 8'h33, 8'h44, 0, 0, 0);
        chk(r_cs_after == 3'b011, "R6 hold second", r_cs_after, 3);
        chk(r_cs_mid == 3'b011 && dat_rdata == 8'h44, "R6 chained data", dat_rdata, 8'h44);
        xfer(EN | 16'h0200, 8'h55, 8'h66, 0, 0, 0);
        chk(r_cs_after == 3'b111, "R6 release after clear", r_cs_after, 7);
    endtask

    task automatic t_irq;
        xfer(EN | IE, 8'h0F, 8'hF0, 0, 0, 0);
        chk(r_irq_end == 1, "R8 irq pulse", r_irq_end, 1);
        chk(r_irq_next == 0, "R8 irq one cycle", r_irq_next, 0);
        xfer(EN, 8'h0F, 8'hF0, 1, EN | IE, 0);
        chk(r_irq_end == 1, "R9 ie set mid", r_irq_end, 1);
        xfer(EN | IE, 8'h0F, 8'hF0, 1, EN | 16'h0003, 0);
        chk(r_irq_end == 0, "R8 ie cleared mid", r_irq_end, 0);
        chk(r_n == 16 * HB + 1, "R9 rate frozen length", r_n, 16 * HB + 1);
        chk(ctl_rdata == EN, "R9 rate field kept", ctl_rdata, EN);
    endtask

    task automatic t_ignore;
        xfer(EN, 8'hC3, 8'h96, 0, 0, 1);
        chk(s_rx == 8'hC3, "R5 busy write no effect on tx", s_rx, 8'hC3);
        chk(dat_rdata == 8'h96, "R5 busy write dropped", dat_rdata, 8'h96);
        wr_ctl(16'h0000);
        dat_wr = 1'b1; dat_wdata = 8'h77;
        @(negedge clk);
        dat_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk(ctl_rdata[7] == 0 && cs_n == 3'b111, "R5 disabled no start", {ctl_rdata[7], cs_n}, 7);
        chk(dat_rdata == 8'h96, "R5 disabled data kept", dat_rdata, 8'h96);
    endtask

    task automatic t_busy;
        wr_ctl(16'hFFFF);
        chk(ctl_rdata == 16'hCB03, "R2 readable bits idle", ctl_rdata, 16'hCB03);
        dat_wr = 1'b1; dat_wdata = 8'h01;
        @(negedge clk);
        dat_wr = 1'b0;
        chk(ctl_rdata == 16'hCB83, "R2 busy bit set", ctl_rdata, 16'hCB83);
        while (ctl_rdata[7]) @(negedge clk);
        chk(ctl_rdata[7] == 0, "R2 busy clears", ctl_rdata[7], 0);
        wr_ctl(16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rates();
        t_devices();
        t_hold();
        t_irq();
        t_ignore();
        t_busy();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule